// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Character Timeout

This block holds the bytes a UART receiver has assembled until the host reads them. In queued mode it stores up to sixteen bytes in arrival order. It reports the fill level and whether the host-selected trigger threshold has been reached. It also raises a pending flag when bytes have sat unread for four character times with no receive or read activity. In single-byte mode it behaves as one holding register that a new byte overwrites.

The deserializer delivers each byte as a one-cycle strobe, and a line break arrives as a separate one-cycle event. The host side drives three strobes: a buffer read, a read of the status flags, and a control write. The control write selects the mode, clears the queue and picks the trigger level. The current line-format bits set the frame length that the timeout is counted in. A free-running baud-rate tick enable advances the timeout.

Top module: `uart_rxq`

## Requirements
- R1: Control write bits [7:6] pick the trigger threshold: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. In queued mode `trig_reached` is high exactly when `level` is at or above the threshold. In single-byte mode it equals `data_ready`.
- R2: In queued mode, a byte arriving when 16 bytes are held is dropped. The stored bytes and `level` stay unchanged, and `overrun` is set.
- R3: An accepted byte appears in `level` and `data_ready` on the next cycle. In queued mode it also restarts the timeout count from zero.
- R4: A read removes the oldest byte. If bytes remain in queued mode, the timeout restarts. If the queue becomes empty, `data_ready` and `brk_flag` clear. Any read, including one of an empty queue, clears `timeout_pend` on the next cycle.
- R5: `rd_data` shows the oldest held byte, and shows 0x00 whenever the queue is empty.
- R6: In queued mode, `timeout_pend` sets when 4 × frame-length baud ticks have been counted since the last restart, but only if at least one byte is then held.
- R7: Frame length in bits is 1 start, plus 5 + `line_cfg[1:0]` data bits, plus 1 parity bit if `line_cfg[3]` is set, plus 1 stop bit (2 if `line_cfg[2]` is set). This gives a 28 to 48 tick window.
- R8: A control write with bit 1 set empties the queue and clears `brk_flag` and `timeout_pend`. It also cancels the timeout. `overrun` is left unchanged.
- R9: `tx_flush` is high in the cycle of a control write whose bit 2 is set, or whose bit 0 differs from the current mode. A change of bit 0 also performs the R8 clear.
- R10: A break event stores a 0x00 byte (subject to R2) and sets `brk_flag`. In that cycle it takes priority over a received byte, which is then lost.
- R11: `ctl_q` holds the last control write masked with 0xC9. Bit 0 selects queued mode, and the value after reset is 0x00 (single-byte mode).
- R12: A status read clears `overrun` and `brk_flag`. An overrun or break in the same cycle wins over the clear.
- R13: In single-byte mode, a byte arriving while one is held replaces it and sets `overrun`. No timeout ever becomes pending in this mode.
- R14: Within one cycle the read is applied before the incoming byte, so a full queue read and written together accepts the byte. A control clear takes priority over every other input in its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| brk_evt | input | 1 | Line break detected strobe |
| rd_en | input | 1 | Host read of the receive buffer |
| flags_rd | input | 1 | Host read of the status flags |
| fcr_wr | input | 1 | Control write strobe |
| fcr_wdata | input | 8 | Control write value |
| line_cfg | input | 4 | Line format: [1:0] data bits − 5, [2] two stop bits, [3] parity on |
| baud_tick | input | 1 | Bit-time tick enable for the timeout |
| rd_data | output | 8 | Oldest held byte, 0x00 when empty |
| level | output | 5 | Number of bytes held |
| data_ready | output | 1 | At least one byte held |
| overrun | output | 1 | A byte was lost or replaced |
| brk_flag | output | 1 | A break was received |
| timeout_pend | output | 1 | Character timeout pending |
| trig_reached | output | 1 | Fill level at or above the trigger |
| ctl_q | output | 8 | Retained control bits |
| tx_flush | output | 1 | Transmit-side queue clear request |

## Verification
The assertions assume that every strobe input is a single-cycle level sampled at the clock and free of X after reset. They also assume that `line_cfg` may change in any cycle. Under that assumption the timeout counter must still terminate when the window shrinks below the current count. The stimulus drives all inputs on the falling edge from a bench model's point of view. It mixes directed sequences, for the full queue, timeout window edges, breaks and mode changes, with a long random phase. That phase draws simultaneous reads, writes, breaks and clears within these rules.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam logic [7:0]  CTL_KEEP_MASK = 8'hC9;

    typedef enum logic [1:0] {
        TRG_ONE      = 2'b00,
        TRG_FOUR     = 2'b01,
        TRG_EIGHT    = 2'b10,
        TRG_FOURTEEN = 2'b11
    } trig_sel_e;

    typedef struct packed {
        trig_sel_e trig;
        logic [1:0] unused_hi;
        logic       dma_sel;
        logic       tx_clr;
        logic       rx_clr;
        logic       queue_on;
    } ctl_t;

    function automatic logic [3:0] trig_bytes(trig_sel_e sel);
        case (sel)
            TRG_ONE:      return 4'd1;
            TRG_FOUR:     return 4'd4;
            TRG_EIGHT:    return 4'd8;
            default:      return 4'd14;
        endcase
    endfunction

    // start + data + optional parity + one or two stop bits
    function automatic logic [3:0] frame_bits(logic [3:0] cfg);
        logic [3:0] n;
        n = 4'd6 + {2'b00, cfg[1:0]};
        n = n + {3'b000, cfg[3]};
        n = n + (cfg[2] ? 4'd2 : 4'd1);
        return n;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8,
    localparam int unsigned LW   = $clog2(DEPTH + 1),
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          cap_one,
    input  logic          pop,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic [LW-1:0] level_nx,
    output logic          pop_ok,
    output logic          acc,
    output logic          repl,
    output logic          drop
);

    logic [PW-1:0] rd_q, wr_q, waddr;
    logic [LW-1:0] level_q, lvl_mid;
    logic          room, wen;
    logic [DEPTH-1:0][W-1:0] slot_vec;

    function automatic logic [PW-1:0] step_ptr(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        pop_ok   = pop && (level_q != '0);
        lvl_mid  = level_q - LW'(pop_ok);
        room     = cap_one ? (lvl_mid == '0) : (lvl_mid != LW'(DEPTH));
        acc      = push && room;
        repl     = push && !room && cap_one;
        drop     = push && !room && !cap_one;
        wen      = acc || repl;
        waddr    = repl ? rd_q : wr_q;
        level_nx = clr ? '0 : (lvl_mid + LW'(acc));
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (wen && !clr && (waddr == PW'(i))) begin
                q <= push_data;
            end
        end
        assign slot_vec[i] = q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_q    <= '0;
            wr_q    <= '0;
            level_q <= '0;
        end else begin
            if (pop_ok) rd_q <= step_ptr(rd_q);
            if (acc)    wr_q <= step_ptr(wr_q);
            level_q <= level_nx;
        end
    end

    assign level = level_q;
    assign head  = (level_q != '0) ? slot_vec[rd_q] : '0;

    p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
        level_q <= LW'(DEPTH));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        (drop && !clr) |=> (level_q == LW'(DEPTH)) && (head == $past(head)));

    p_single_cap_r13: assert property (@(posedge clk) disable iff (rst)
        (cap_one && !clr && $past(cap_one)) |-> (level_q <= LW'(1)));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
    import uart_rxq_pkg::*;
#(
    parameter int unsigned TMO_CHARS = 4,
    localparam int unsigned CW       = $clog2(TMO_CHARS * 12 + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cancel,
    input  logic       restart,
    input  logic       tick,
    input  logic [3:0] line_cfg,
    input  logic       pend_clr,
    input  logic       data_left,
    output logic       pend
);

    logic [CW-1:0] cnt_q, window;
    logic          armed_q, pend_q, expire;

    always_comb begin
        window = CW'(TMO_CHARS) * CW'(frame_bits(line_cfg));
        expire = armed_q && tick && (cnt_q >= window - CW'(1)) && !restart && !cancel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (cancel) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else if (restart) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (armed_q && tick) begin
                if (expire) begin
                    armed_q <= 1'b0;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
            if (pend_clr)                pend_q <= 1'b0;
            else if (expire && data_left) pend_q <= 1'b1;
        end
    end

    assign pend = pend_q;

    p_read_clears_pend_r4: assert property (@(posedge clk) disable iff (rst)
        pend_clr |=> !pend_q);

    p_count_in_window_r7: assert property (@(posedge clk) disable iff (rst)
        (armed_q && restart) |=> (cnt_q == '0));

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned TMO_CHARS = 4,
    localparam int unsigned LW       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              brk_evt,
    input  logic              rd_en,
    input  logic              flags_rd,
    input  logic              fcr_wr,
    input  logic [7:0]        fcr_wdata,
    input  logic [3:0]        line_cfg,
    input  logic              baud_tick,
    output logic [BYTE_W-1:0] rd_data,
    output logic [LW-1:0]     level,
    output logic              data_ready,
    output logic              overrun,
    output logic              brk_flag,
    output logic              timeout_pend,
    output logic              trig_reached,
    output logic [7:0]        ctl_q,
    output logic              tx_flush
);

    ctl_t              ctl_r, ctl_in;
    logic              mode_flip, rx_clr;
    logic              push, pop;
    logic [BYTE_W-1:0] push_data;
    logic [LW-1:0]     lvl, lvl_nx;
    logic              pop_ok, acc, repl, drop, restart;
    logic              ovr_q, brk_q;

    always_comb begin
        ctl_in    = ctl_t'(fcr_wdata);
        mode_flip = ctl_in.queue_on != ctl_r.queue_on;
        rx_clr    = fcr_wr && (ctl_in.rx_clr || mode_flip);
        tx_flush  = fcr_wr && (ctl_in.tx_clr || mode_flip);
        push      = !rx_clr && (brk_evt || rx_valid);
        push_data = brk_evt ? '0 : rx_byte;
        pop       = rd_en && !rx_clr;
    end

    rxq_store #(.DEPTH(DEPTH), .W(BYTE_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (rx_clr),
        .cap_one   (!ctl_r.queue_on),
        .pop       (pop),
        .push      (push),
        .push_data (push_data),
        .head      (rd_data),
        .level     (lvl),
        .level_nx  (lvl_nx),
        .pop_ok    (pop_ok),
        .acc       (acc),
        .repl      (repl),
        .drop      (drop)
    );

    assign restart = ctl_r.queue_on && (acc || (pop_ok && (lvl_nx != '0)));

    rxq_timer #(.TMO_CHARS(TMO_CHARS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .cancel    (rx_clr),
        .restart   (restart),
        .tick      (baud_tick),
        .line_cfg  (line_cfg),
        .pend_clr  (rx_clr || rd_en),
        .data_left (lvl_nx != '0),
        .pend      (timeout_pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_r <= '0;
            ovr_q <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            if (fcr_wr) ctl_r <= ctl_t'(fcr_wdata & CTL_KEEP_MASK);

            if (drop || repl)  ovr_q <= 1'b1;
            else if (flags_rd) ovr_q <= 1'b0;

            if (rx_clr)                        brk_q <= 1'b0;
            else if (brk_evt)                  brk_q <= 1'b1;
            else if (flags_rd)                 brk_q <= 1'b0;
            else if (rd_en && (lvl_nx == '0))  brk_q <= 1'b0;
        end
    end

    assign level        = lvl;
    assign data_ready   = (lvl != '0);
    assign overrun      = ovr_q;
    assign brk_flag     = brk_q;
    assign ctl_q        = ctl_r;
    assign trig_reached = ctl_r.queue_on ? (lvl >= LW'(trig_bytes(ctl_r.trig)))
                                         : (lvl != '0);

    p_rx_clear_r8: assert property (@(posedge clk) disable iff (rst)
        rx_clr |=> (level == '0) && !brk_flag && !timeout_pend);

    p_pend_needs_data_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_pend) |-> (level != '0));

    p_break_has_data_r10: assert property (@(posedge clk) disable iff (rst)
        brk_flag |-> data_ready);

    p_single_no_timeout_r13: assert property (@(posedge clk) disable iff (rst)
        (!ctl_r.queue_on && $past(!ctl_r.queue_on)) |-> !$rose(timeout_pend));

endmodule

// File: tb/sim_uart_rxq.sv
module sim_uart_rxq;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 0, brk_evt = 0, rd_en = 0, flags_rd = 0, fcr_wr = 0, baud_tick = 0;
    logic [7:0] rx_byte = 0, fcr_wdata = 0;
    logic [3:0] line_cfg = 0;
    logic [7:0] rd_data, ctl_q;
    logic [4:0] level;
    logic       data_ready, overrun, brk_flag, timeout_pend, trig_reached, tx_flush;

    int nchk = 0, nfail = 0;

    // reference model state
    logic [7:0] mq[$];
    bit   m_en, m_ovr, m_brk, m_pend, m_armed;
    int   m_cnt;
    logic [7:0] m_ctl;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rxq u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .brk_evt(brk_evt),
        .rd_en(rd_en), .flags_rd(flags_rd), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
        .line_cfg(line_cfg), .baud_tick(baud_tick), .rd_data(rd_data), .level(level),
        .data_ready(data_ready), .overrun(overrun), .brk_flag(brk_flag),
        .timeout_pend(timeout_pend), .trig_reached(trig_reached), .ctl_q(ctl_q),
        .tx_flush(tx_flush)
    );

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int trig_of(logic [1:0] s);
        case (s) 2'b00: return 1; 2'b01: return 4; 2'b10: return 8; default: return 14; endcase
    endfunction

    function automatic int win_of(logic [3:0] c);   // R7 frame length times four
        int fb;
        fb = 1 + 5 + int'(c[1:0]) + int'(c[3]) + (c[2] ? 2 : 1);
        return 4 * fb;
    endfunction

    task automatic m_reset();
        mq.delete();
        m_en = 0; m_ovr = 0; m_brk = 0; m_pend = 0; m_armed = 0; m_cnt = 0; m_ctl = 0;
    endtask

    task automatic m_step();
        bit rx_rst, popped, acc, ovr_set, restart;
        logic [7:0] pb;
        if (rst) begin m_reset(); return; end
        rx_rst = fcr_wr && (fcr_wdata[1] || (fcr_wdata[0] != m_en));
        if (rx_rst) begin
            mq.delete(); m_brk = 0; m_pend = 0; m_armed = 0; m_cnt = 0;
            if (flags_rd) m_ovr = 0;
        end else begin
            popped = 0; acc = 0; ovr_set = 0;
            if (rd_en && mq.size() > 0) begin void'(mq.pop_front()); popped = 1; end
            if (brk_evt || rx_valid) begin
                pb = brk_evt ? 8'h00 : rx_byte;
                if (mq.size() < (m_en ? DEPTH : 1)) begin mq.push_back(pb); acc = 1; end
                else if (!m_en) begin mq[0] = pb; ovr_set = 1; end
                else ovr_set = 1;
            end
            if (flags_rd) begin m_ovr = 0; m_brk = 0; end
            if (rd_en && mq.size() == 0) m_brk = 0;
            if (ovr_set) m_ovr = 1;
            if (brk_evt) m_brk = 1;
            if (rd_en) m_pend = 0;
            restart = m_en && (acc || (popped && mq.size() > 0));
            if (restart) begin m_armed = 1; m_cnt = 0; end
            else if (m_armed && baud_tick) begin
                if (m_cnt >= win_of(line_cfg) - 1) begin
                    m_armed = 0; m_cnt = 0;
                    if (mq.size() > 0 && !rd_en) m_pend = 1;
                end else m_cnt++;
            end
        end
        if (fcr_wr) begin m_en = fcr_wdata[0]; m_ctl = fcr_wdata & 8'hC9; end
    endtask

    task automatic compare_all();
        int sz;
        sz = mq.size();
        chk("R5", "rd_data", rd_data, sz > 0 ? mq[0] : 0);
        chk("R3", "level", level, sz);
        chk("R4", "data_ready", data_ready, sz > 0);
        chk("R2", "overrun", overrun, m_ovr);
        chk("R10", "brk_flag", brk_flag, m_brk);
        chk("R6", "timeout_pend", timeout_pend, m_pend);
        chk("R1", "trig_reached", trig_reached, m_en ? (sz >= trig_of(m_ctl[7:6])) : (sz > 0));
        chk("R11", "ctl_q", ctl_q, m_ctl);
    endtask

    task automatic cyc();
        #1;
        chk("R9", "tx_flush", tx_flush, fcr_wr && (fcr_wdata[2] || (fcr_wdata[0] != m_en)));
        @(posedge clk);
        m_step();
        @(negedge clk);
        compare_all();
        rx_valid = 0; brk_evt = 0; rd_en = 0; flags_rd = 0; fcr_wr = 0; baud_tick = 0;
    endtask

    task automatic rx(logic [7:0] b); rx_valid = 1; rx_byte = b; cyc(); endtask
    task automatic rd(); rd_en = 1; cyc(); endtask
    task automatic fcr(logic [7:0] v); fcr_wr = 1; fcr_wdata = v; cyc(); endtask
    task automatic ticks(int n); for (int i = 0; i < n; i++) begin baud_tick = 1; cyc(); end endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        m_reset();
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;
        @(posedge clk); m_step(); @(negedge clk);
        // reset state
        chk("R11", "reset ctl_q", ctl_q, 0);
        chk("R3", "reset level", level, 0);
        chk("R5", "reset rd_data", rd_data, 0);
        compare_all();

        // R13 single-byte mode: overwrite sets overrun
        rx(8'h11); rx(8'h22);
        chk("R13", "held byte replaced", rd_data, 8'h22);
        chk("R13", "overrun on replace", overrun, 1);
        ticks(60);
        chk("R13", "no timeout single mode", timeout_pend, 0);
        flags_rd = 1; cyc();
        chk("R12", "status read clears overrun", overrun, 0);
        rd();

        // R9/R11 enable queue, trigger 4
        fcr(8'h4F);
        chk("R11", "masked control", ctl_q, 8'h49);
        for (int i = 0; i < 3; i++) rx(8'hA0 + 8'(i));
        chk("R1", "below trigger 4", trig_reached, 0);
        rx(8'hA3);
        chk("R1", "at trigger 4", trig_reached, 1);
        for (int i = 0; i < 4; i++) begin
            chk("R4", "read order", rd_data, 8'hA0 + i);
            rd();
        end
        chk("R4", "drained data_ready", data_ready, 0);
        rd();
        chk("R5", "empty read zero", rd_data, 0);

        // R2 fill and overflow
        for (int i = 0; i < DEPTH + 2; i++) rx(8'(i + 1));
        chk("R2", "full level", level, DEPTH);
        chk("R2", "overrun set", overrun, 1);
        chk("R2", "head kept", rd_data, 1);
        // R14 read and write together when full
        rd_en = 1; rx_valid = 1; rx_byte = 8'hEE; cyc();
        chk("R14", "full read+write level", level, DEPTH);
        chk("R12", "overrun stays", overrun, 1);
        flags_rd = 1; rx_valid = 1; rx_byte = 8'h55; cyc();
        chk("R12", "set wins over clear", overrun, 1);
        fcr(8'h03);
        chk("R8", "rx reset empties", level, 0);
        chk("R8", "overrun untouched", overrun, 1);

        // R6/R7 timeout window, 7-bit frame -> 28 ticks
        line_cfg = 4'h0;
        rx(8'h5A);
        ticks(27);
        chk("R6", "no pend at 27", timeout_pend, 0);
        ticks(1);
        chk("R6", "pend at 28", timeout_pend, 1);
        rd();
        chk("R4", "read clears pend", timeout_pend, 0);
        // 12-bit frame -> 48 ticks
        line_cfg = 4'hF;
        rx(8'h01); rx(8'h02); rd();
        ticks(47);
        chk("R7", "no pend at 47", timeout_pend, 0);
        ticks(1);
        chk("R7", "pend at 48", timeout_pend, 1);
        rd();
        // empty at expiry: no pend
        rx(8'h03); rd(); ticks(60);
        chk("R6", "no pend when empty", timeout_pend, 0);
        // reset cancels armed timeout
        rx(8'h04); ticks(10); fcr(8'h03); rx(8'h05);
        ticks(47);
        chk("R8", "cancel restarts window", timeout_pend, 0);
        fcr(8'h03);

        // R10 break
        rx(8'h77); brk_evt = 1; rx_valid = 1; rx_byte = 8'h99; cyc();
        chk("R10", "break level", level, 2);
        chk("R10", "break flag", brk_flag, 1);
        rd();
        chk("R10", "break byte zero", rd_data, 0);
        chk("R10", "flag held while data", brk_flag, 1);
        rd();
        chk("R4", "empty clears break", brk_flag, 0);

        // trigger 8 and 14
        fcr(8'h81);
        for (int i = 0; i < 8; i++) rx(8'(i));
        chk("R1", "trigger 8", trig_reached, 1);
        fcr(8'hC1);
        chk("R8", "bit1 not set keeps data", level, 8);
        chk("R1", "trigger 14 not yet", trig_reached, 0);
        for (int i = 0; i < 6; i++) rx(8'(i));
        chk("R1", "trigger 14", trig_reached, 1);
        fcr(8'h05);
        chk("R9", "tx only keeps data", level, 14);
        fcr(8'h00);
        chk("R9", "mode flip clears", level, 0);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            rx_valid  = ($urandom % 3) == 0;
            rx_byte   = 8'($urandom);
            brk_evt   = ($urandom % 40) == 0;
            rd_en     = ($urandom % 4) == 0;
            flags_rd  = ($urandom % 16) == 0;
            baud_tick = ($urandom % 2) == 0;
            fcr_wr    = ($urandom % 80) == 0;
            fcr_wdata = 8'($urandom) | 8'h01;
            if (($urandom % 400) == 0) fcr_wdata[0] = 1'b0;
            if (($urandom % 300) == 0) line_cfg = 4'($urandom);
            cyc();
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule